// File: doc/BRIEF.md
# Parity-Predicting Integer ALU with Refetch and Retry

This block is a small integer execution unit that never lets a silently corrupted result out. Operands arrive from the level-1 cache read port together with one parity bit each, and that parity is kept next to the data in the operand registers. The parity bits also feed a predictor that works out the parity the result should have, from the operand parities and the internal carry vector. The predictor does not recompute the result. A wrong bit produced anywhere inside the adder or the logic unit therefore shows up as a mismatch between the predicted parity and the parity of the actual result. A stored operand whose parity no longer matches its data is caught by its own check.

When either check fails, the block commits nothing. It wipes its operand registers, requests the same two operands from the cache again, and executes the same instruction once more. A retried instruction that then completes delivers its result exactly once, together with a corrected-error pulse. If failures continue beyond a parameterised number of retries, the block raises a sticky unrecoverable flag and stops accepting work. The core can then be isolated while other cores keep running. A fault-injection input flips one selected result bit during execute, so that detection and recovery can be exercised.

Top module: `parity_alu_retry`

## Requirements
- R1: Out of reset, issue_ready is 1 and fetch_req, res_valid, corr_err and unrecov are all 0.
- R2: Opcode 2'b00 adds: res_data equals (A + B) modulo 2^W.
- R3: Opcode 2'b01 subtracts: res_data equals (A - B) modulo 2^W.
- R4: Opcode 2'b10 gives the bitwise AND of A and B, and opcode 2'b11 gives the bitwise XOR.
- R5: Parity is even: every delivered res_par equals the XOR of all bits of res_data, and a fill is well formed when fetch_par_x equals the XOR of all bits of fetch_data_x.
- R6: After an issue is accepted, issue_ready is 0. fetch_req stays 1, with fetch_addr_a and fetch_addr_b equal to the issued addresses, until a cycle in which fetch_ack is 1.
- R7: An execute attempt with inj_en high flips result bit inj_bit. That attempt delivers no result, and fetch_req is 1 again in the very next cycle (refetch).
- R8: A fill whose parity does not match its data causes the same outcome as R7: no result from that attempt, and an immediate refetch.
- R9: A result committed after one or more failed attempts comes with corr_err high in the same single cycle. A result committed at the first attempt has corr_err low. Each instruction produces exactly one res_valid pulse.
- R10: When attempt number MAX_RETRY+1 of an instruction fails, unrecov goes to 1 and stays there until reset, with no result delivered, and issue_ready and fetch_req held at 0.
- R11: When fetch_ack is sampled at clock edge k, res_valid is 0 in the cycle after edge k, and the attempt's outcome (a result or a refetch) is visible in the cycle after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | The unit is idle and takes the instruction |
| issue_op | input | 2 | 00 add, 01 subtract, 10 AND, 11 XOR |
| issue_addr_a | input | ADDR_W | Cache address of operand A |
| issue_addr_b | input | ADDR_W | Cache address of operand B |
| fetch_req | output | 1 | Operand read request to the cache |
| fetch_addr_a | output | ADDR_W | Requested address of operand A |
| fetch_addr_b | output | ADDR_W | Requested address of operand B |
| fetch_ack | input | 1 | Cache returns both operands this cycle |
| fetch_data_a | input | W | Operand A data |
| fetch_par_a | input | 1 | Operand A parity |
| fetch_data_b | input | W | Operand B data |
| fetch_par_b | input | 1 | Operand B parity |
| inj_en | input | 1 | Flip one result bit in the execute cycle |
| inj_bit | input | clog2(W) | Index of the bit to flip |
| res_valid | output | 1 | One-cycle pulse: result committed |
| res_data | output | W | Committed result |
| res_par | output | 1 | Parity carried with the result |
| corr_err | output | 1 | Pulse with res_valid when a retry was needed |
| unrecov | output | 1 | Sticky: retries exhausted, unit is dead |

## Verification
Two functions can land in the same execute cycle: the operand-register parity check and the predicted-versus-actual result check. The bench provokes this by filling an operand with wrong parity while also injecting a result-bit flip on the same attempt. With one retry allowed, the instruction must still recover. The combined failure must consume a single retry, and the bench judges this from the corrected result and the corr_err pulse rather than from an unrecoverable flag. The same instruction-level outcome check also covers a commit and its corrected-error pulse, which must share one cycle. All four operations are swept exhaustively over every operand pair at a 4-bit width, and every flip position is checked for detection on every operation.

// File: rtl/palu_pkg.sv
// Package: shared opcode and controller state types for the parity ALU.
// Assumes: nothing; pure type definitions.
package palu_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FETCH = 2'b01,
        ST_EXEC  = 2'b10,
        ST_DEAD  = 2'b11
    } ctl_state_e;
endpackage

// File: rtl/palu_datapath.sv
// Module: palu_datapath
// Computes add, subtract, AND and XOR of two W-bit operands using an
// explicit ripple carry vector, which it exports for parity prediction.
// A single result bit can be flipped for fault injection.
// Assumes: W >= 2; purely combinational.
module palu_datapath
    import palu_pkg::*;
#(
    parameter int W = 32,
    localparam int IDX_W = $clog2(W)
) (
    input  alu_op_e          op,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic             inj_en,
    input  logic [IDX_W-1:0] inj_bit,
    output logic [W-1:0]     carry_vec,
    output logic [W-1:0]     result
);
    logic [W-1:0] b_eff;
    logic [W-1:0] raw;
    logic [W-1:0] flip_mask;

    // Operand B is inverted for subtraction, and the carry-in becomes 1.
    always_comb begin
        b_eff = (op == OP_SUB) ? ~opb : opb;
    end

    assign carry_vec[0] = (op == OP_SUB);

    // Carry into each bit position, one stage per bit.
    for (genvar i = 0; i < W - 1; i++) begin : g_carry
        assign carry_vec[i+1] = (opa[i] & b_eff[i]) |
                                (opa[i] & carry_vec[i]) |
                                (b_eff[i] & carry_vec[i]);
    end

    // Select the operation result.
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: raw = opa ^ b_eff ^ carry_vec;
            OP_AND:         raw = opa & opb;
            default:        raw = opa ^ opb;
        endcase
    end

    // Optional single-bit corruption of the result.
    always_comb begin
        flip_mask = inj_en ? ({{(W-1){1'b0}}, 1'b1} << inj_bit) : '0;
        result    = raw ^ flip_mask;
    end
endmodule

// File: rtl/palu_parity_pred.sv
// Module: palu_parity_pred
// Predicts the parity of the ALU result from the operand parity bits and
// the carry vector, without recomputing the result itself.
// Assumes: parities are even (XOR of data bits); combinational.
module palu_parity_pred
    import palu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic         par_a,
    input  logic         par_b,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] carry_vec,
    output logic         pred_par
);
    // Inverting W bits flips the parity when W is odd.
    localparam logic INV_FLIP = (W % 2) == 1;

    logic carry_par;
    logic or_par;

    // Parities of the carry vector and of the OR vector.
    always_comb begin
        carry_par = ^carry_vec;
        or_par    = ^(opa | opb);
    end

    // Per-operation prediction; AND uses a&b = (a^b) ^ (a|b) bitwise.
    always_comb begin
        unique case (op)
            OP_ADD:  pred_par = par_a ^ par_b ^ carry_par;
            OP_SUB:  pred_par = par_a ^ par_b ^ INV_FLIP ^ carry_par;
            OP_AND:  pred_par = par_a ^ par_b ^ or_par;
            default: pred_par = par_a ^ par_b;
        endcase
    end
endmodule

// File: rtl/palu_retry_ctrl.sv
// Module: palu_retry_ctrl
// Sequences accept, fetch and execute, counts failed attempts, and either
// refetches or enters a terminal dead state after MAX_RETRY retries.
// Assumes: attempt_bad is valid in the execute cycle; synchronous reset.
module palu_retry_ctrl
    import palu_pkg::*;
#(
    parameter int MAX_RETRY = 1,
    localparam int CNT_W = $clog2(MAX_RETRY + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_valid,
    input  logic fetch_ack,
    input  logic attempt_bad,
    output logic issue_ready,
    output logic fetch_req,
    output logic load_ops,
    output logic clear_ops,
    output logic commit,
    output logic retried,
    output logic dead
);
    ctl_state_e       state_q;
    logic [CNT_W-1:0] fails_q;

    // State and failed-attempt counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fails_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (issue_valid) begin
                    state_q <= ST_FETCH;
                    fails_q <= '0;
                end
                ST_FETCH: if (fetch_ack) state_q <= ST_EXEC;
                ST_EXEC: begin
                    if (!attempt_bad) begin
                        state_q <= ST_IDLE;
                    end else if (fails_q == CNT_W'(MAX_RETRY)) begin
                        state_q <= ST_DEAD;
                    end else begin
                        state_q <= ST_FETCH;
                        fails_q <= fails_q + 1'b1;
                    end
                end
                default: state_q <= ST_DEAD;
            endcase
        end
    end

    // Decoded strobes for the datapath registers and ports.
    always_comb begin
        issue_ready = (state_q == ST_IDLE);
        fetch_req   = (state_q == ST_FETCH);
        load_ops    = fetch_req && fetch_ack;
        clear_ops   = (state_q == ST_EXEC) && attempt_bad;
        commit      = (state_q == ST_EXEC) && !attempt_bad;
        retried     = (fails_q != '0);
        dead        = (state_q == ST_DEAD);
    end
endmodule

// File: rtl/parity_alu_retry.sv
// Module: parity_alu_retry (top)
// Parity-protected ALU: operands are fetched with parity, both operand
// parities and a predicted result parity are checked in execute, and a
// failure clears the operand registers and retries from the cache.
// Assumes: the cache returns both operands in the fetch_ack cycle.
module parity_alu_retry
    import palu_pkg::*;
#(
    parameter int W         = 32,
    parameter int ADDR_W    = 12,
    parameter int MAX_RETRY = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_valid,
    output logic                 issue_ready,
    input  logic [1:0]           issue_op,
    input  logic [ADDR_W-1:0]    issue_addr_a,
    input  logic [ADDR_W-1:0]    issue_addr_b,
    output logic                 fetch_req,
    output logic [ADDR_W-1:0]    fetch_addr_a,
    output logic [ADDR_W-1:0]    fetch_addr_b,
    input  logic                 fetch_ack,
    input  logic [W-1:0]         fetch_data_a,
    input  logic                 fetch_par_a,
    input  logic [W-1:0]         fetch_data_b,
    input  logic                 fetch_par_b,
    input  logic                 inj_en,
    input  logic [$clog2(W)-1:0] inj_bit,
    output logic                 res_valid,
    output logic [W-1:0]         res_data,
    output logic                 res_par,
    output logic                 corr_err,
    output logic                 unrecov
);
    alu_op_e           op_q;
    logic [ADDR_W-1:0] addr_a_q, addr_b_q;
    logic [W-1:0]      opa_q, opb_q;
    logic              pa_q, pb_q;
    logic [W-1:0]      carry_vec, alu_res;
    logic              pred_par;
    logic              reg_bad, alu_bad, attempt_bad;
    logic              load_ops, clear_ops, commit, retried;

    // Instruction register, captured on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_ADD;
            addr_a_q <= '0;
            addr_b_q <= '0;
        end else if (issue_valid && issue_ready) begin
            op_q     <= alu_op_e'(issue_op);
            addr_a_q <= issue_addr_a;
            addr_b_q <= issue_addr_b;
        end
    end

    // Operand registers with parity: loaded on fill, wiped after a failure.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_ops) begin
            opa_q <= '0;
            opb_q <= '0;
            pa_q  <= 1'b0;
            pb_q  <= 1'b0;
        end else if (load_ops) begin
            opa_q <= fetch_data_a;
            opb_q <= fetch_data_b;
            pa_q  <= fetch_par_a;
            pb_q  <= fetch_par_b;
        end
    end

    palu_datapath #(.W(W)) u_dp (
        .op        (op_q),
        .opa       (opa_q),
        .opb       (opb_q),
        .inj_en    (inj_en),
        .inj_bit   (inj_bit),
        .carry_vec (carry_vec),
        .result    (alu_res)
    );

    palu_parity_pred #(.W(W)) u_pred (
        .op        (op_q),
        .par_a     (pa_q),
        .par_b     (pb_q),
        .opa       (opa_q),
        .opb       (opb_q),
        .carry_vec (carry_vec),
        .pred_par  (pred_par)
    );

    // Register parity check and predicted-versus-actual result check.
    always_comb begin
        reg_bad     = ((^opa_q) != pa_q) || ((^opb_q) != pb_q);
        alu_bad     = ((^alu_res) != pred_par);
        attempt_bad = reg_bad || alu_bad;
    end

    palu_retry_ctrl #(.MAX_RETRY(MAX_RETRY)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .fetch_ack   (fetch_ack),
        .attempt_bad (attempt_bad),
        .issue_ready (issue_ready),
        .fetch_req   (fetch_req),
        .load_ops    (load_ops),
        .clear_ops   (clear_ops),
        .commit      (commit),
        .retried     (retried),
        .dead        (unrecov)
    );

    // Result register: written once per instruction, carrying predicted parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            corr_err  <= 1'b0;
            res_data  <= '0;
            res_par   <= 1'b0;
        end else begin
            res_valid <= commit;
            corr_err  <= commit && retried;
            if (commit) begin
                res_data <= alu_res;
                res_par  <= pred_par;
            end
        end
    end

    assign fetch_addr_a = addr_a_q;
    assign fetch_addr_b = addr_b_q;
endmodule

// File: rtl/palu_checker.sv
// Module: palu_checker
// Port-level temporal checks for parity_alu_retry, bound to the top.
// Assumes: synchronous active-low reset.
module palu_checker #(
    parameter int W      = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_ready,
    input logic              fetch_req,
    input logic              fetch_ack,
    input logic [ADDR_W-1:0] fetch_addr_a,
    input logic [ADDR_W-1:0] fetch_addr_b,
    input logic              res_valid,
    input logic [W-1:0]      res_data,
    input logic              res_par,
    input logic              corr_err,
    input logic              unrecov
);
    // R5: predicted parity delivered with a result matches the result.
    a_r5_result_parity: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_par == ^res_data));

    // R6: a pending request holds its addresses.
    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr_a) && $stable(fetch_addr_b)));

    // R6: never ready while fetching.
    a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> !issue_ready);

    // R9: corrected-error pulse only accompanies a result.
    a_r9_corr_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        corr_err |-> res_valid);

    // R10: unrecoverable state is sticky.
    a_r10_unrecov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        unrecov |=> unrecov);

    // R10: a dead unit is silent.
    a_r10_silent_when_dead: assert property (@(posedge clk) disable iff (!rst_n)
        unrecov |-> (!res_valid && !issue_ready && !fetch_req));

    // R11: no result in the cycle right after a fill.
    a_r11_no_result_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack) |=> !res_valid);
endmodule

bind parity_alu_retry palu_checker #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_ready  (issue_ready),
    .fetch_req    (fetch_req),
    .fetch_ack    (fetch_ack),
    .fetch_addr_a (fetch_addr_a),
    .fetch_addr_b (fetch_addr_b),
    .res_valid    (res_valid),
    .res_data     (res_data),
    .res_par      (res_par),
    .corr_err     (corr_err),
    .unrecov      (unrecov)
);

// File: tb/parity_alu_retry_tb_top.sv
`timescale 1ns/1ps
module parity_alu_retry_tb_top;
    localparam int W     = 4;
    localparam int AW    = 4;
    localparam int MAXR  = 1;
    localparam int IDX_W = $clog2(W);
    localparam int MASK  = (1 << W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             issue_valid = 1'b0;
    logic             issue_ready;
    logic [1:0]       issue_op = '0;
    logic [AW-1:0]    issue_addr_a = '0, issue_addr_b = '0;
    logic             fetch_req;
    logic [AW-1:0]    fetch_addr_a, fetch_addr_b;
    logic             fetch_ack = 1'b0;
    logic [W-1:0]     fetch_data_a = '0, fetch_data_b = '0;
    logic             fetch_par_a = 1'b0, fetch_par_b = 1'b0;
    logic             inj_en = 1'b0;
    logic [IDX_W-1:0] inj_bit = '0;
    logic             res_valid;
    logic [W-1:0]     res_data;
    logic             res_par;
    logic             corr_err;
    logic             unrecov;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    parity_alu_retry #(.W(W), .ADDR_W(AW), .MAX_RETRY(MAXR)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_op(issue_op),
        .issue_addr_a(issue_addr_a), .issue_addr_b(issue_addr_b),
        .fetch_req(fetch_req), .fetch_addr_a(fetch_addr_a), .fetch_addr_b(fetch_addr_b),
        .fetch_ack(fetch_ack), .fetch_data_a(fetch_data_a), .fetch_par_a(fetch_par_a),
        .fetch_data_b(fetch_data_b), .fetch_par_b(fetch_par_b),
        .inj_en(inj_en), .inj_bit(inj_bit),
        .res_valid(res_valid), .res_data(res_data), .res_par(res_par),
        .corr_err(corr_err), .unrecov(unrecov)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int expect_of(input int op, input int a, input int b);
        case (op)
            0:       return (a + b) & MASK;
            1:       return (a + (1 << W) - b) & MASK;
            2:       return a & b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic bit par_of(input int v);
        bit p = 1'b0;
        for (int i = 0; i < W; i++) p ^= v[i];
        return p;
    endfunction

    // Runs one instruction; the first bad_n fills carry wrong parity on A,
    // the first inj_n executes get a flipped bit. Returns 1 if unit died.
    task automatic run_op(input int op, input int a, input int b, input int lat,
                          input int bad_n, input int inj_n, input int ibit,
                          output bit died);
        int exp_v = expect_of(op, a, b);
        logic [AW-1:0] xa = AW'(a + 3);
        logic [AW-1:0] xb = AW'(b + 5);
        died = 1'b0;
        @(negedge clk);
        check(issue_ready == 1'b1, "R6 ready before issue", issue_ready, 1);
        issue_valid  = 1'b1;
        issue_op     = 2'(op);
        issue_addr_a = xa;
        issue_addr_b = xb;
        @(posedge clk);
        #1 issue_valid = 1'b0;
        for (int att = 0; att <= MAXR; att++) begin
            bit fail_now = (att < bad_n) || (att < inj_n);
            @(negedge clk);
            check(fetch_req == 1'b1, "R6/R7/R8 fetch request raised", fetch_req, 1);
            check(issue_ready == 1'b0, "R6 busy during fetch", issue_ready, 0);
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                check(fetch_req == 1'b1, "R6 request held", fetch_req, 1);
            end
            check(fetch_addr_a == xa && fetch_addr_b == xb, "R6 fetch addresses",
                  {fetch_addr_a, fetch_addr_b}, {xa, xb});
            fetch_ack    = 1'b1;
            fetch_data_a = W'(a);
            fetch_data_b = W'(b);
            fetch_par_a  = par_of(a) ^ (att < bad_n);
            fetch_par_b  = par_of(b);
            inj_en       = (att < inj_n);
            inj_bit      = IDX_W'(ibit);
            @(posedge clk);
            #1 fetch_ack = 1'b0;
            @(negedge clk);
            check(res_valid == 1'b0, "R11 no result right after fill", res_valid, 0);
            @(posedge clk);
            #1 inj_en = 1'b0;
            @(negedge clk);
            if (fail_now) begin
                check(res_valid == 1'b0, "R7/R8 faulty attempt not committed", res_valid, 0);
                if (att == MAXR) begin
                    check(unrecov == 1'b1, "R10 unrecov after last failure", unrecov, 1);
                    check(fetch_req == 1'b0, "R10 no refetch when dead", fetch_req, 0);
                    died = 1'b1;
                    return;
                end
                check(unrecov == 1'b0, "R7/R8 still recoverable", unrecov, 0);
            end else begin
                check(res_valid == 1'b1, "R11 result timing", res_valid, 1);
                check(int'(res_data) == exp_v,
                      op == 0 ? "R2 add" : op == 1 ? "R3 sub" : "R4 logic", res_data, exp_v);
                check(res_par == par_of(exp_v), "R5 result parity", res_par, par_of(exp_v));
                check(corr_err == (att > 0), "R9 corrected pulse", corr_err, att > 0);
                if (att > 0) begin
                    @(negedge clk);
                    check(res_valid == 1'b0 && corr_err == 1'b0, "R9 single pulse",
                          {res_valid, corr_err}, 0);
                end
                return;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(issue_ready == 1'b1, "R1 reset issue_ready", issue_ready, 1);
        check({fetch_req, res_valid, corr_err, unrecov} == 4'b0, "R1 reset outputs",
              {fetch_req, res_valid, corr_err, unrecov}, 0);
    endtask

    initial begin
        bit died;
        do_reset();
        // Exhaustive sweep of all operations and operand pairs.
        for (int op = 0; op < 4; op++)
            for (int a = 0; a <= MASK; a++)
                for (int b = 0; b <= MASK; b++) begin
                    run_op(op, a, b, (a + b) % 2, 0, 0, 0, died);
                    check(!died, "R2/R3/R4 unit alive", died, 0);
                end
        // R7: every injected bit position on every op recovers after one retry.
        for (int op = 0; op < 4; op++)
            for (int bit_i = 0; bit_i < W; bit_i++) begin
                run_op(op, 9 + bit_i, 6, 0, 0, 1, bit_i, died);
                check(!died, "R7 single flip recovers", died, 0);
            end
        // R8: bad operand parity on the first fill recovers.
        for (int op = 0; op < 4; op++) begin
            run_op(op, 13, 7 - op, 1, 1, 0, 0, died);
            check(!died, "R8 bad parity recovers", died, 0);
        end
        // Both checks fail on the same attempt: one retry only.
        run_op(0, 11, 14, 0, 1, 1, 2, died);
        check(!died, "R7/R8 combined failure uses one retry", died, 0);
        // R10: failures on every attempt exhaust the retries.
        run_op(1, 5, 12, 0, 0, MAXR + 1, 3, died);
        check(died, "R10 retries exhausted", died, 1);
        issue_valid = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(unrecov == 1'b1 && issue_ready == 1'b0 && res_valid == 1'b0,
                  "R10 dead state held", {unrecov, issue_ready, res_valid}, 3'b100);
        end
        issue_valid = 1'b0;
        do_reset();
        run_op(3, 10, 3, 0, 0, 0, 0, died);
        check(!died, "R1 works after reset", died, 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R6 run did not complete actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule